// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a serial peripheral interface master that software drives through a small 32-bit register window. Software writes bytes into a 16-entry transmit queue. The block shifts each byte out on the serial data output, one bit per serial clock period, and captures the same number of bits from the serial data input. Each received byte goes into a 16-entry receive queue. The control register sets clock polarity and phase, bit order and internal loopback, and gates transfers with an enable, a master bit and an inhibit bit. The same register flushes either queue.

Slave selects are active low and come from a select register. In manual mode the register drives the select pins at all times. In automatic mode the selects are driven only while a byte is on the wire. The block also has a status register, two occupancy registers and a soft-reset register that acts only when it sees one key value. The interrupt register slots exist in the address map but hold no state.

Top module: `spim_top`

## Requirements
- R1: After reset the registers read as follows: control 0x180 (inhibit bit8 and manual select bit7 set), status 0x25, select register all ones, and both occupancy registers 0. SCLK is 0 and every ss_n is high.
- R2: Byte addresses: soft reset 0x40, control 0x60, status 0x64, transmit data 0x68, receive data 0x6C, select 0x70, transmit occupancy 0x74, receive occupancy 0x78. The interrupt slots 0x1C, 0x20 and 0x28 read 0 and ignore writes. Read data appears on bus_rdata one cycle after the read strobe.
- R3: The transmit queue holds 16 bytes, and a write to 0x68 while it is full is dropped. Status bit3 is TX full and bit2 is TX empty. Register 0x74 reads the entry count minus one, or 0 when the queue is empty.
- R4: A transfer starts only when control bit1 (enable) and bit2 (master) are 1 and bit8 (inhibit) is 0. Otherwise queued bytes stay where they are.
- R5: SCLK idles at control bit3 (CPOL). With bit4 (CPHA) at 0, data is sampled on the first edge of each clock pair; with CPHA at 1, it is sampled on the second edge. Bits go MSB first unless bit9 is set, which selects LSB first. Each SCLK half period lasts 2**DIV_LOG2 system clocks.
- R6: Every byte shifted out pushes one received byte into the 16-entry receive queue, and the bytes are read back in order. When the queue is full, the received byte is dropped. Status bit0 is RX empty and bit1 is RX full. Register 0x78 reads the count minus one, or 0 when the queue is empty.
- R7: A read of 0x6C while the receive queue is empty returns 0 and leaves the queue empty. Only bits 7:0 of the data registers carry data.
- R8: When control bit0 (loopback) is 1, the receive shifter takes the MOSI value and MISO has no effect.
- R9: Writing 1 to control bit5 empties the transmit queue, and writing 1 to bit6 empties the receive queue. Both bits read back as 0.
- R10: Select register bit n low selects slave n. With control bit7 set, ss_n follows the select register. With bit7 clear, ss_n follows the register only while a byte is being shifted and is all ones otherwise.
- R11: Writing 0x0A to 0x40 returns every register and both queues to their reset state. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The bench builds the block with DIV_LOG2 = 1 and NSS = 4, so a byte takes about 34 system clocks. With transfers that short, filling and draining both 16-entry queues, including a byte that overflows each queue, fits well within the run. A slave model follows SCLK edges in all four clock modes and both bit orders. It checks the MOSI byte and supplies a MISO byte that differs from it, so a swapped sample and shift edge, or a loopback path that leaks MISO, shows up as a wrong byte.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 10;

    localparam logic [ADDR_W-1:0] OFS_GIE   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_ISR   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IER   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_SRST  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_SSEL  = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_TXOCC = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_RXOCC = 8'h78;

    localparam logic [BUS_W-1:0] SRST_KEY = 32'h0000_000A;

    // control word, bit 9 down to bit 0
    typedef struct packed {
        logic lsb_first;
        logic inhibit;
        logic manual_ss;
        logic rx_flush;
        logic tx_flush;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loopback;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(10'h180);

    // status word, bit 5 down to bit 0
    typedef struct packed {
        logic slave_sel;
        logic mode_fault;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } stat_t;

    typedef enum logic [3:0] {
        RS_NONE, RS_IRQ, RS_SRST, RS_CTRL, RS_STAT, RS_TXD,
        RS_RXD, RS_SSEL, RS_TXOCC, RS_RXOCC
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_GIE, OFS_ISR, OFS_IER: s = RS_IRQ;
            OFS_SRST:  s = RS_SRST;
            OFS_CTRL:  s = RS_CTRL;
            OFS_STAT:  s = RS_STAT;
            OFS_TXD:   s = RS_TXD;
            OFS_RXD:   s = RS_RXD;
            OFS_SSEL:  s = RS_SSEL;
            OFS_TXOCC: s = RS_TXOCC;
            OFS_RXOCC: s = RS_RXOCC;
            default:   s = RS_NONE;
        endcase
        return s;
    endfunction

    // occupancy reads as count minus one, floored at zero
    function automatic logic [BUS_W-1:0] occ_word(input logic [15:0] cnt);
        logic [15:0] v;
        v = (cnt == 16'd0) ? 16'd0 : cnt - 16'd1;
        return {16'd0, v};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         empty,
    output logic                         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rp_q];
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && wp_q == PW'(gi)) begin
                    mem_q[gi] <= wdata;
                end
            end
        end
    endgenerate

    // R3 / R6: occupancy never exceeds the queue depth
    p_fifo_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int DIV_LOG2 = 1,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         loopback,
    input  logic         miso,
    output logic         busy,
    output logic         sclk,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int EDGES = 2 * W;
    localparam int EW    = $clog2(EDGES);

    logic                busy_q, phase_q, done_q;
    logic [DIV_LOG2-1:0] tmr_q;
    logic [EW-1:0]       edge_q;
    logic [W-1:0]        sr_q, rsr_q;
    logic                tick, samp, last, rx_in;

    assign tick  = busy_q && (&tmr_q);
    assign samp  = (edge_q[0] == cpha);
    assign last  = (edge_q == EW'(EDGES-1));
    assign mosi  = lsb_first ? sr_q[0] : sr_q[W-1];
    assign rx_in = loopback ? mosi : miso;

    assign busy    = busy_q;
    assign sclk    = cpol ^ phase_q;
    assign done    = done_q;
    assign rx_byte = rsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            done_q  <= 1'b0;
            tmr_q   <= '0;
            edge_q  <= '0;
            sr_q    <= '0;
            rsr_q   <= '0;
        end else begin
            done_q <= tick && last;
            if (!busy_q && start) begin
                busy_q  <= 1'b1;
                sr_q    <= tx_byte;
                tmr_q   <= '0;
                edge_q  <= '0;
                phase_q <= 1'b0;
            end else if (busy_q) begin
                tmr_q <= tmr_q + 1'b1;
                if (tick) begin
                    phase_q <= ~phase_q;
                    edge_q  <= edge_q + 1'b1;
                    if (samp) begin
                        rsr_q <= lsb_first ? {rx_in, rsr_q[W-1:1]}
                                           : {rsr_q[W-2:0], rx_in};
                    end else if (edge_q != '0 && !last) begin
                        sr_q <= lsb_first ? (sr_q >> 1) : (sr_q << 1);
                    end
                    if (last) begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end
    end

    // R5: after a whole byte the clock phase is back at its idle level
    p_phase_home_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !phase_q);

    // R5: the half-period timer only runs while a byte is in flight
    p_timer_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy_q && !$past(busy_q) |-> tmr_q == '0);

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int DIV_LOG2   = 1,
    parameter int NSS        = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NSS-1:0]    ss_n
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    reg_sel_e         sel;
    ctrl_t            ctrl_q, ctrl_wr;
    stat_t            stat;
    logic [NSS-1:0]   ssr_q;
    logic             soft_q, rst_int;
    logic [BUS_W-1:0] rdata_q;

    logic             tx_push, tx_pop, tx_clr, tx_empty, tx_full;
    logic             rx_pop, rx_clr, rx_empty, rx_full;
    logic [BYTE_W-1:0] tx_head, rx_head, sh_rx;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             sh_busy, sh_done, go;

    assign sel     = decode_addr(bus_addr);
    assign ctrl_wr = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign rst_int = rst || soft_q;

    // keyed soft reset: one-cycle pulse that resets everything next edge
    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q <= 1'b0;
        end else begin
            soft_q <= bus_wr && (sel == RS_SRST) && (bus_wdata == SRST_KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_int) begin
            ctrl_q <= CTRL_RST;
            ssr_q  <= '1;
        end else if (bus_wr) begin
            if (sel == RS_CTRL) begin
                ctrl_q          <= ctrl_wr;
                ctrl_q.tx_flush <= 1'b0;
                ctrl_q.rx_flush <= 1'b0;
            end
            if (sel == RS_SSEL) begin
                ssr_q <= bus_wdata[NSS-1:0];
            end
        end
    end

    assign tx_clr  = bus_wr && (sel == RS_CTRL) && ctrl_wr.tx_flush;
    assign rx_clr  = bus_wr && (sel == RS_CTRL) && ctrl_wr.rx_flush;
    assign tx_push = bus_wr && (sel == RS_TXD);
    assign rx_pop  = bus_rd && (sel == RS_RXD) && !rx_empty;
    assign go      = ctrl_q.enable && ctrl_q.master && !ctrl_q.inhibit
                     && !tx_empty && !sh_busy;
    assign tx_pop  = go;

    spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst_int), .clr(tx_clr),
        .push(tx_push), .wdata(bus_wdata[BYTE_W-1:0]),
        .pop(tx_pop), .head(tx_head), .cnt(tx_cnt),
        .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst_int), .clr(rx_clr),
        .push(sh_done), .wdata(sh_rx),
        .pop(rx_pop), .head(rx_head), .cnt(rx_cnt),
        .empty(rx_empty), .full(rx_full)
    );

    spim_shift #(.DIV_LOG2(DIV_LOG2), .W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst_int), .start(go), .tx_byte(tx_head),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .lsb_first(ctrl_q.lsb_first), .loopback(ctrl_q.loopback),
        .miso(miso), .busy(sh_busy), .sclk(sclk), .mosi(mosi),
        .done(sh_done), .rx_byte(sh_rx)
    );

    always_comb begin
        stat            = '0;
        stat.slave_sel  = 1'b1;
        stat.mode_fault = 1'b0;
        stat.tx_full    = tx_full;
        stat.tx_empty   = tx_empty;
        stat.rx_full    = rx_full;
        stat.rx_empty   = rx_empty;
    end

    assign ss_n = (ctrl_q.manual_ss || sh_busy) ? ssr_q : '1;

    always_ff @(posedge clk) begin
        if (rst_int) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (sel)
                RS_CTRL:  rdata_q <= {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
                RS_STAT:  rdata_q <= {{(BUS_W-6){1'b0}}, stat};
                RS_RXD:   rdata_q <= rx_empty ? '0 : {{(BUS_W-BYTE_W){1'b0}}, rx_head};
                RS_SSEL:  rdata_q <= {{(BUS_W-NSS){1'b0}}, ssr_q};
                RS_TXOCC: rdata_q <= occ_word(16'(tx_cnt));
                RS_RXOCC: rdata_q <= occ_word(16'(rx_cnt));
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    // R4: a byte starts only under enable, master and no inhibit
    p_no_start_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_busy) |-> $past(ctrl_q.enable && ctrl_q.master && !ctrl_q.inhibit));

    // R6: a finished byte lands in a non-full receive queue
    p_push_per_byte_r6: assert property (@(posedge clk) disable iff (rst)
        $past(sh_done && !rx_full && !rx_pop && !rx_clr && !rst_int)
        |-> rx_cnt == $past(rx_cnt) + CW'(1));

    // R11: the keyed pulse leaves the control register at its reset value
    p_soft_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(soft_q) |-> ctrl_q == CTRL_RST && ssr_q == '1);

    // R10: automatic select mode keeps all selects high when idle
    p_auto_ss_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(ctrl_q.manual_ss) && !$past(sh_busy) && !$past(rst_int)
        && !ctrl_q.manual_ss && !sh_busy |-> ss_n == '1);

endmodule

// File: tb/test_spim_top.sv
module test_spim_top;
    localparam int DIV_LOG2 = 1;
    localparam int NSS      = 4;

    localparam logic [7:0] A_SRST = 8'h40, A_CTRL = 8'h60, A_STAT = 8'h64,
                           A_TXD = 8'h68, A_RXD = 8'h6C, A_SSEL = 8'h70,
                           A_TXOCC = 8'h74, A_RXOCC = 8'h78;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    wire  [31:0] bus_rdata;
    wire         sclk, mosi;
    logic        miso;
    wire [NSS-1:0] ss_n;

    spim_top #(.DIV_LOG2(DIV_LOG2), .NSS(NSS), .FIFO_DEPTH(16)) i_spim_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    // slave model configuration, written by the stimulus only
    logic [7:0] sl_byte = 8'h00;
    bit         sl_cpha = 1'b0, sl_lsb = 1'b0;
    int         arm_id  = 0;
    // slave model state, written by the model only
    int         seen_id = 0, k = 0, mi = 0;
    logic       prev_sclk;
    logic [7:0] cap;

    function automatic logic bitsel(input logic [7:0] b, input int n, input bit lsb);
        return lsb ? b[n] : b[7-n];
    endfunction

    always @(negedge clk) begin
        if (arm_id != seen_id) begin
            seen_id   = arm_id;
            k         = 0;
            prev_sclk = sclk;
            cap       = 8'h00;
            if (!sl_cpha) begin
                miso = bitsel(sl_byte, 0, sl_lsb);
                mi   = 1;
            end else begin
                miso = 1'b0;
                mi   = 0;
            end
        end else if (sclk !== prev_sclk) begin
            prev_sclk = sclk;
            if ((k % 2) == int'(sl_cpha)) begin
                cap = sl_lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
            end else begin
                if (mi < 8) miso = bitsel(sl_byte, mi, sl_lsb);
                mi++;
            end
            k++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] stat_exp(input int txc, input int rxc);
        return 32'h20 | ((txc == 16) ? 32'h8 : 0) | ((txc == 0) ? 32'h4 : 0)
                      | ((rxc == 16) ? 32'h2 : 0) | ((rxc == 0) ? 32'h1 : 0);
    endfunction

    function automatic logic [31:0] occ_exp(input int c);
        return (c == 0) ? 32'h0 : 32'(c - 1);
    endfunction

    function automatic logic [31:0] ctrl_word(input bit cpol, input bit cpha, input bit lsb,
                                              input bit loop, input bit manual, input bit inh);
        return 32'h6 | (cpol ? 32'h8 : 0) | (cpha ? 32'h10 : 0) | (lsb ? 32'h200 : 0)
                     | (loop ? 32'h1 : 0) | (manual ? 32'h80 : 0) | (inh ? 32'h100 : 0);
    endfunction

    task automatic wait_rx();
        logic [31:0] s;
        for (int i = 0; i < 100; i++) begin
            rd(A_STAT, s);
            if (!s[0]) break;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input bit cpol,
                        input bit cpha, input bit lsb, input bit loop);
        logic [31:0] r;
        wr(A_CTRL, ctrl_word(cpol, cpha, lsb, loop, 1'b1, 1'b0));
        sl_byte = sb; sl_cpha = cpha; sl_lsb = lsb; arm_id++;
        @(negedge clk);
        wr(A_TXD, {24'hABCDEF, tx});
        wait_rx();
        rd(A_RXD, r);
        if (loop) chk("R8 loopback receive byte", r, {24'h0, tx});
        else      chk("R5/R6 received byte", r, {24'h0, sb});
        chk("R5 MOSI byte", {24'h0, cap}, {24'h0, tx});
        chk("R5 SCLK idle level", {31'h0, sclk}, {31'h0, cpol});
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  q [16];
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, r);  chk("R1 control reset", r, 32'h180);
        rd(A_STAT, r);  chk("R1 status reset", r, 32'h25);
        rd(A_SSEL, r);  chk("R1 select reset", r, 32'hF);
        rd(A_TXOCC, r); chk("R1 tx occupancy reset", r, 0);
        rd(A_RXOCC, r); chk("R1 rx occupancy reset", r, 0);
        chk("R1 sclk/ss_n reset", {27'h0, sclk, ss_n}, {27'h0, 1'b0, 4'hF});

        // R2 interrupt slots hold nothing
        wr(8'h1C, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h1C, r); chk("R2 slot 0x1C", r, 0);
        rd(8'h20, r); chk("R2 slot 0x20", r, 0);
        rd(8'h28, r); chk("R2 slot 0x28", r, 0);

        // R4 gating, each case flushing the TX queue first (R9)
        for (int g = 0; g < 3; g++) begin
            logic [31:0] cw;
            cw = (g == 0) ? 32'h186 : (g == 1) ? 32'h84 : 32'h82;
            wr(A_CTRL, cw | 32'h20);
            rd(A_STAT, r); chk("R9 tx flush empties", r, stat_exp(0, 0));
            rd(A_CTRL, r); chk("R9 flush bit reads 0", r, cw);
            wr(A_TXD, 32'h5A);
            repeat (60) @(negedge clk);
            rd(A_STAT, r); chk("R4 gated: byte still queued", r, stat_exp(1, 0));
            chk("R4 gated: sclk idle", {31'h0, sclk}, 0);
        end

        // R3 fill 17 under inhibit
        wr(A_CTRL, 32'h1A7);
        for (int i = 0; i < 17; i++) wr(A_TXD, 32'((i * 37 + 3) & 8'hFF));
        rd(A_TXOCC, r); chk("R3 tx occupancy full", r, occ_exp(16));
        rd(A_STAT, r);  chk("R3 tx full status", r, stat_exp(16, 0));

        // release: loopback drains 16 bytes into RX (R6)
        wr(A_CTRL, 32'h087);
        repeat (16 * 40) @(negedge clk);
        rd(A_STAT, r);  chk("R6 rx full status", r, stat_exp(0, 16));
        rd(A_RXOCC, r); chk("R6 rx occupancy full", r, occ_exp(16));
        wr(A_TXD, 32'hEE);
        repeat (60) @(negedge clk);
        rd(A_RXOCC, r); chk("R6 overflow byte dropped", r, occ_exp(16));
        for (int i = 0; i < 16; i++) begin
            rd(A_RXD, r); chk("R6 rx order", r, 32'((i * 37 + 3) & 8'hFF));
        end
        rd(A_RXD, r);   chk("R7 empty read returns 0", r, 0);
        rd(A_RXOCC, r); chk("R7 queue stays empty", r, 0);
        rd(A_STAT, r);  chk("R7 status after empty read", r, stat_exp(0, 0));

        // R9 rx flush
        wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        repeat (90) @(negedge clk);
        rd(A_RXOCC, r); chk("R6 two bytes received", r, occ_exp(2));
        wr(A_CTRL, 32'h087 | 32'h40);
        rd(A_STAT, r);  chk("R9 rx flush empties", r, stat_exp(0, 0));
        rd(A_CTRL, r);  chk("R9 rx flush bit reads 0", r, 32'h087);

        // R10 manual and automatic selects
        wr(A_SSEL, 32'hE);
        @(negedge clk);
        chk("R10 manual select", {28'h0, ss_n}, 32'hE);
        wr(A_CTRL, 32'h007);
        wr(A_SSEL, 32'hD);
        @(negedge clk);
        chk("R10 auto idle deasserted", {28'h0, ss_n}, 32'hF);
        wr(A_TXD, 32'h3C);
        repeat (6) @(negedge clk);
        chk("R10 auto asserted during byte", {28'h0, ss_n}, 32'hD);
        wait_rx();
        chk("R10 auto released after byte", {28'h0, ss_n}, 32'hF);
        rd(A_RXD, r);   chk("R8 auto-mode loopback byte", r, 32'h3C);

        // R5 R6 R8 random transfers over all modes
        for (int t = 0; t < 40; t++) begin
            logic [7:0] tx, sb;
            logic [3:0] m;
            tx = 8'($urandom);
            sb = 8'($urandom);
            if (sb == tx) sb = ~tx;
            m  = 4'($urandom);
            if (t < 8) m = 4'(t);
            xfer(tx, sb, m[0], m[1], m[2], (m[3] && t >= 8));
        end
        // directed extremes
        xfer(8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        xfer(8'h01, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0);
        xfer(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);

        // R11 soft reset key
        wr(A_CTRL, 32'h31E);
        wr(A_SSEL, 32'h3);
        wr(A_SRST, 32'h05);
        repeat (3) @(negedge clk);
        rd(A_CTRL, r); chk("R11 wrong key ignored (ctrl)", r, 32'h31E);
        rd(A_SSEL, r); chk("R11 wrong key ignored (select)", r, 32'h3);
        wr(A_TXD, 32'h77);
        wr(A_SRST, 32'h0A);
        repeat (3) @(negedge clk);
        rd(A_CTRL, r);  chk("R11 key resets control", r, 32'h180);
        rd(A_SSEL, r);  chk("R11 key resets select", r, 32'hF);
        rd(A_STAT, r);  chk("R11 key empties queues", r, 32'h25);
        rd(A_TXOCC, r); chk("R11 tx occupancy after key", r, 0);

        summary();
    end
endmodule